// File: doc/BRIEF.md
# Row-Based Cross-Lane Operand Fetch Unit

This unit sits in front of a vector datapath. It hands each of 64 lanes an operand taken from another lane of the same wavefront. The lanes form four rows of sixteen. Inside each row, groups of four consecutive lanes make up four banks. On an issue cycle an opcode and an argument byte choose the source lane for every destination lane, and every source stays inside the destination's row.

Three things decide what a lane finally receives: its own execute bit, a per-row enable and a per-bank enable. Two further controls set the treatment of bad sources. One says whether an invalid source writes zero. The other says whether a source lane whose execute bit is clear still supplies its value. A narrow mode limits the work to the lower two rows. Results appear one clock after issue, and a lane that is not written keeps its last result.

Top module: `xl_share_unit`

## Requirements
- R1: After reset every lane result is zero and `vld_o` is low. An `issue_i` sampled high at a rising edge updates `dst_o` at that edge. `vld_o` is then high for the one following cycle and low in any cycle not preceded by an issue.
- R2: Quad permute, op 0. A lane at position k (0..3) within its group of four reads the lane of the same group whose position is `arg_i[2k+1:2k]`.
- R3: Op 1 (full-row mirror) reads in-row index 15-p. Op 2 (half-row mirror) reads 7-p for p<8 and 23-p for p>=8. Here p is the destination's in-row index.
- R4: Op 3 (row share) reads in-row index `arg_i[3:0]` for every lane of the row. Op 4 (row XOR) reads index p XOR `arg_i[3:0]`.
- R5: The shift amount n is `arg_i[3:0]`. Op 5 reads p+n and is valid only when p+n<16. Op 6 reads p-n and is valid only when p>=n. Op 7 reads (p-n) mod 16 and is always valid.
- R6: A source is invalid if it lies past the row edge or if the opcode is 8..15. For an invalid source, an enabled destination gets zero when `zero_oob_i`=1 and keeps its old result when `zero_oob_i`=0.
- R7: A valid source whose `exec_i` bit is clear is delivered unchanged when `fetch_inact_i`=1. When `fetch_inact_i`=0 it is treated as invalid under R6.
- R8: A destination lane keeps its result when any one of three bits is clear: its own `exec_i` bit, `row_en_i[lane/16]`, or `bank_en_i[(lane mod 16)/4]`.
- R9: With `wave32_i`=1, lanes 32..63 keep their results and lanes 0..31 work normally.
- R10: In a cycle without an issue, no result changes, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_i | input | 1 | Apply the control set and capture results this edge |
| op_i | input | 4 | Source-selection opcode (0..7 defined) |
| arg_i | input | 8 | Quad selectors, share index, XOR value or shift amount |
| row_en_i | input | 4 | Per-row destination enable |
| bank_en_i | input | 4 | Per-bank destination enable |
| zero_oob_i | input | 1 | Invalid source writes zero |
| fetch_inact_i | input | 1 | Inactive source lanes still supply data |
| wave32_i | input | 1 | Restrict to the lower two rows |
| exec_i | input | 64 | Per-lane execute mask |
| src_i | input | 2048 | Lane operands, lane l at bits [32l+31:32l] |
| vld_o | output | 1 | Results updated on the previous edge |
| dst_o | output | 2048 | Per-lane results, same packing as `src_i` |

## Verification
Some properties are checked on every cycle. The valid strobe must follow issue by exactly one cycle. Results must stay frozen in cycles without an issue. A lane whose own execute bit is clear, a lane in a disabled row, and any upper-half lane in narrow mode must all hold their results across an issue. The bench's directed scenarios show what no per-cycle property can express here: the source index chosen by every opcode, the row-edge cutoff of the shifts, the zero-versus-keep choice for invalid sources, delivery of data from inactive sources, and bank gating. Each scenario computes the expected results from the requirement text and compares every lane.

// File: rtl/xl_pkg.sv
package xl_pkg;
  localparam int ARG_W = 8;
  localparam int OP_W  = 4;

  typedef enum logic [OP_W-1:0] {
    OP_QPERM  = 4'd0,
    OP_RMIRR  = 4'd1,
    OP_HMIRR  = 4'd2,
    OP_RSHARE = 4'd3,
    OP_RXOR   = 4'd4,
    OP_SHL    = 4'd5,
    OP_SHR    = 4'd6,
    OP_ROR    = 4'd7
  } op_e;
endpackage

// File: rtl/xl_rst_sync.sv
module xl_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/xl_src_map.sv
// Per-lane source index generator; LANE_POS is the lane's in-row index.
module xl_src_map
  import xl_pkg::*;
#(
  parameter int ROW_LANES = 16,
  parameter int LANE_POS  = 0
) (
  input  logic [OP_W-1:0]             op_i,
  input  logic [ARG_W-1:0]            arg_i,
  output logic [$clog2(ROW_LANES)-1:0] src_idx_o,
  output logic                        in_row_o
);
  localparam int IDX_W = $clog2(ROW_LANES);
  localparam logic [IDX_W-1:0] POS = IDX_W'(LANE_POS);
  localparam int QPOS = LANE_POS % 4;

  logic [1:0]       qsel [4];
  logic [IDX_W-1:0] amt;
  logic [IDX_W:0]   sum;

  always_comb begin
    for (int k = 0; k < 4; k++) qsel[k] = arg_i[2*k +: 2];
  end

  assign amt = arg_i[IDX_W-1:0];
  assign sum = {1'b0, POS} + {1'b0, amt};

  always_comb begin
    src_idx_o = POS;
    in_row_o  = 1'b1;
    case (op_e'(op_i))
      OP_QPERM:  src_idx_o = {POS[IDX_W-1:2], qsel[QPOS]};
      OP_RMIRR:  src_idx_o = ~POS;
      OP_HMIRR:  src_idx_o = {POS[IDX_W-1], ~POS[IDX_W-2:0]};
      OP_RSHARE: src_idx_o = amt;
      OP_RXOR:   src_idx_o = POS ^ amt;
      OP_SHL: begin
        src_idx_o = sum[IDX_W-1:0];
        in_row_o  = ~sum[IDX_W];
      end
      OP_SHR: begin
        src_idx_o = POS - amt;
        in_row_o  = (POS >= amt);
      end
      OP_ROR:    src_idx_o = POS - amt;
      default:   in_row_o  = 1'b0;
    endcase
  end
endmodule

// File: rtl/xl_lane_reg.sv
module xl_lane_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic              src_ok_i,
  input  logic              src_act_i,
  input  logic              fetch_inact_i,
  input  logic              zero_oob_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic [DATA_W-1:0] q_o
);
  logic              take;
  logic              en;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    take = src_ok_i & (src_act_i | fetch_inact_i);
    en   = upd_i & (take | zero_oob_i);
    nxt  = take ? src_data_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  q_o <= '0;
    else if (en)  q_o <= nxt;
  end
endmodule

// File: rtl/xl_share_unit.sv
module xl_share_unit
  import xl_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ROW_LANES = 16,
  parameter int NUM_ROWS  = 4,
  parameter int NUM_BANKS = 4
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  issue_i,
  input  logic [OP_W-1:0]                       op_i,
  input  logic [ARG_W-1:0]                      arg_i,
  input  logic [NUM_ROWS-1:0]                   row_en_i,
  input  logic [NUM_BANKS-1:0]                  bank_en_i,
  input  logic                                  zero_oob_i,
  input  logic                                  fetch_inact_i,
  input  logic                                  wave32_i,
  input  logic [ROW_LANES*NUM_ROWS-1:0]         exec_i,
  input  logic [ROW_LANES*NUM_ROWS*DATA_W-1:0]  src_i,
  output logic                                  vld_o,
  output logic [ROW_LANES*NUM_ROWS*DATA_W-1:0]  dst_o
);
  localparam int LANES      = ROW_LANES * NUM_ROWS;
  localparam int LANE_W     = $clog2(LANES);
  localparam int IDX_W      = $clog2(ROW_LANES);
  localparam int BANK_LANES = ROW_LANES / NUM_BANKS;

  logic              rst_sync_n;
  logic              vld_d;
  logic              vld_q;
  logic [DATA_W-1:0] src_lane [LANES];

  xl_rst_sync u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_sync_n)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_unpack
    assign src_lane[g] = src_i[g*DATA_W +: DATA_W];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int   ROW   = g / ROW_LANES;
    localparam int   POS   = g % ROW_LANES;
    localparam int   BANK  = POS / BANK_LANES;
    localparam logic UPPER = 1'(g >= LANES / 2);

    logic [IDX_W-1:0]  sidx;
    logic              in_row;
    logic [LANE_W-1:0] slane;
    logic              dst_en;

    xl_src_map #(
      .ROW_LANES (ROW_LANES),
      .LANE_POS  (POS)
    ) u_map (
      .op_i      (op_i),
      .arg_i     (arg_i),
      .src_idx_o (sidx),
      .in_row_o  (in_row)
    );

    assign slane  = LANE_W'(ROW * ROW_LANES) | LANE_W'(sidx);
    assign dst_en = issue_i & exec_i[g] & row_en_i[ROW] & bank_en_i[BANK]
                  & ~(wave32_i & UPPER);

    xl_lane_reg #(
      .DATA_W (DATA_W)
    ) u_reg (
      .clk_i         (clk_i),
      .rst_ni        (rst_sync_n),
      .upd_i         (dst_en),
      .src_ok_i      (in_row),
      .src_act_i     (exec_i[slane]),
      .fetch_inact_i (fetch_inact_i),
      .zero_oob_i    (zero_oob_i),
      .src_data_i    (src_lane[slane]),
      .q_o           (dst_o[g*DATA_W +: DATA_W])
    );
  end

  always_comb vld_d = issue_i;

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) vld_q <= 1'b0;
    else             vld_q <= vld_d;
  end

  assign vld_o = vld_q;
endmodule

// File: rtl/xl_share_chk.sv
module xl_share_chk #(
  parameter int DATA_W    = 32,
  parameter int ROW_LANES = 16,
  parameter int NUM_ROWS  = 4
) (
  input logic                                 clk_i,
  input logic                                 rst_ni,
  input logic                                 issue_i,
  input logic [ROW_LANES*NUM_ROWS-1:0]        exec_i,
  input logic [NUM_ROWS-1:0]                  row_en_i,
  input logic                                 wave32_i,
  input logic                                 vld_o,
  input logic [ROW_LANES*NUM_ROWS*DATA_W-1:0] dst_o
);
  localparam int LANES = ROW_LANES * NUM_ROWS;
  localparam int ROW_W = ROW_LANES * DATA_W;
  localparam int HALF  = LANES * DATA_W / 2;

  AST_VLD_AFTER_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |=> vld_o); // R1
  AST_VLD_LOW_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> !vld_o); // R1
  AST_IDLE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> $stable(dst_o)); // R10
  AST_NARROW_UPPER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && wave32_i |=> $stable(dst_o[LANES*DATA_W-1:HALF])); // R9

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    AST_ROW_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_i && !row_en_i[r] |=> $stable(dst_o[r*ROW_W +: ROW_W])); // R8
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    AST_EXEC_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_i && !exec_i[l] |=> $stable(dst_o[l*DATA_W +: DATA_W])); // R8
  end
endmodule

bind xl_share_unit xl_share_chk #(
  .DATA_W    (DATA_W),
  .ROW_LANES (ROW_LANES),
  .NUM_ROWS  (NUM_ROWS)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_sync_n),
  .issue_i  (issue_i),
  .exec_i   (exec_i),
  .row_en_i (row_en_i),
  .wave32_i (wave32_i),
  .vld_o    (vld_o),
  .dst_o    (dst_o)
);

// File: tb/xl_share_unit_tb_top.sv
`timescale 1ns/100ps
module xl_share_unit_tb_top;
  localparam int W  = 32;
  localparam int NL = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          issue;
  logic [3:0]    op;
  logic [7:0]    arg;
  logic [3:0]    row_en;
  logic [3:0]    bank_en;
  logic          zero_oob;
  logic          fetch_inact;
  logic          wave32;
  logic [NL-1:0] exec;
  logic [NL*W-1:0] src;
  logic          vld;
  logic [NL*W-1:0] dst;

  logic [W-1:0] exp_q [NL];
  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  xl_share_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .op_i(op), .arg_i(arg),
    .row_en_i(row_en), .bank_en_i(bank_en), .zero_oob_i(zero_oob),
    .fetch_inact_i(fetch_inact), .wave32_i(wave32), .exec_i(exec),
    .src_i(src), .vld_o(vld), .dst_o(dst)
  );

  function automatic logic [W-1:0] lane_val(input logic [15:0] seed, input int l);
    return {seed, 8'hA5 ^ 8'(l), 8'(l)};
  endfunction

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, expv);
    end
  endtask

  task automatic chk_lanes(input string req);
    int bad_lane = -1;
    n_cmp++;
    for (int l = 0; l < NL; l++)
      if (dst[l*W +: W] !== exp_q[l] && bad_lane < 0) bad_lane = l;
    if (bad_lane >= 0) begin
      n_bad++;
      $display("FAIL %s: lane %0d actual %h expected %h", req, bad_lane,
               dst[bad_lane*W +: W], exp_q[bad_lane]);
    end
  endtask

  // Drive one issue, update the model from the requirement rules, check.
  task automatic do_issue(input string req, input logic [3:0] o, input logic [7:0] a,
                          input logic [3:0] re, input logic [3:0] be,
                          input logic zo, input logic fi, input logic w32,
                          input logic [NL-1:0] ex, input logic [15:0] seed);
    @(negedge clk);
    op = o; arg = a; row_en = re; bank_en = be; zero_oob = zo;
    fetch_inact = fi; wave32 = w32; exec = ex;
    for (int l = 0; l < NL; l++) src[l*W +: W] = lane_val(seed, l);
    issue = 1'b1;
    for (int l = 0; l < NL; l++) begin
      int row = l / 16;
      int p = l % 16;
      int n = int'(a[3:0]);
      int s = p;
      bit ok = 1;
      if (!(ex[l] && re[row] && be[p/4] && !(w32 && l >= 32))) continue;
      case (o)
        4'd0: s = (p & 12) + ((int'(a) >> ((p % 4) * 2)) & 3);
        4'd1: s = 15 - p;
        4'd2: s = (p < 8) ? 7 - p : 23 - p;
        4'd3: s = n;
        4'd4: s = p ^ n;
        4'd5: begin s = p + n; ok = (s < 16); end
        4'd6: begin s = p - n; ok = (p >= n); end
        4'd7: s = (p - n + 16) % 16;
        default: ok = 0;
      endcase
      if (ok && (ex[row*16 + s] || fi)) exp_q[l] = lane_val(seed, row*16 + s);
      else if (zo) exp_q[l] = '0;
    end
    @(negedge clk);
    issue = 1'b0;
    chk_bit({req, " vld"}, vld, 1'b1);
    chk_lanes(req);
  endtask

  localparam logic [NL-1:0] ALL = '1;

  task automatic t_reset();
    for (int l = 0; l < NL; l++) exp_q[l] = '0;
    chk_bit("R1 reset vld", vld, 1'b0);
    chk_lanes("R1 reset data");
  endtask

  task automatic t_quad();
    do_issue("R2 quad reverse", 4'd0, 8'b00_01_10_11, 4'hF, 4'hF, 1, 0, 0, ALL, 16'h1001);
    do_issue("R2 quad mixed",   4'd0, 8'b01_01_00_10, 4'hF, 4'hF, 1, 0, 0, ALL, 16'h1002);
  endtask

  task automatic t_mirror();
    do_issue("R3 row mirror",  4'd1, 8'h00, 4'hF, 4'hF, 1, 0, 0, ALL, 16'h2001);
    do_issue("R3 half mirror", 4'd2, 8'h00, 4'hF, 4'hF, 1, 0, 0, ALL, 16'h2002);
  endtask

  task automatic t_share_xor();
    do_issue("R4 row share", 4'd3, 8'h05, 4'hF, 4'hF, 1, 0, 0, ALL, 16'h3001);
    do_issue("R4 row xor",   4'd4, 8'h09, 4'hF, 4'hF, 1, 0, 0, ALL, 16'h3002);
  endtask

  task automatic t_shift();
    do_issue("R5 R6 shl zero edge",  4'd5, 8'h03, 4'hF, 4'hF, 1, 0, 0, ALL, 16'h4001);
    do_issue("R5 R6 shr keep edge",  4'd6, 8'h05, 4'hF, 4'hF, 0, 0, 0, ALL, 16'h4002);
    do_issue("R5 ror wrap",          4'd7, 8'h07, 4'hF, 4'hF, 0, 0, 0, ALL, 16'h4003);
    do_issue("R5 shl max keep",      4'd5, 8'h0F, 4'hF, 4'hF, 0, 0, 0, ALL, 16'h4004);
  endtask

  task automatic t_reserved();
    do_issue("R6 reserved keep", 4'd9,  8'h00, 4'hF, 4'hF, 0, 0, 0, ALL, 16'h5001);
    do_issue("R6 reserved zero", 4'd12, 8'h00, 4'hF, 4'hF, 1, 0, 0, ALL, 16'h5002);
  endtask

  task automatic t_inactive();
    do_issue("R7 inactive zero",  4'd4, 8'h04, 4'hF, 4'hF, 1, 0, 0,
             64'hF0F0_F0F0_F0F0_F0F0, 16'h6001);
    do_issue("R7 inactive fetch", 4'd4, 8'h04, 4'hF, 4'hF, 1, 1, 0,
             64'hF0F0_F0F0_F0F0_F0F0, 16'h6002);
    do_issue("R7 inactive keep",  4'd1, 8'h00, 4'hF, 4'hF, 0, 0, 0,
             64'h00FF_00FF_00FF_00FF, 16'h6003);
  endtask

  task automatic t_masks();
    do_issue("R8 row mask",  4'd1, 8'h00, 4'b0101, 4'hF, 1, 0, 0, ALL, 16'h7001);
    do_issue("R8 bank mask", 4'd2, 8'h00, 4'hF, 4'b1001, 1, 0, 0, ALL, 16'h7002);
    do_issue("R8 exec mask", 4'd3, 8'h02, 4'hF, 4'hF, 1, 1, 0,
             64'h8421_8421_8421_8421, 16'h7003);
  endtask

  task automatic t_wave32();
    do_issue("R9 narrow mode", 4'd7, 8'h01, 4'hF, 4'hF, 1, 0, 1, ALL, 16'h8001);
  endtask

  task automatic t_idle();
    @(negedge clk);
    issue = 1'b0; op = 4'd3; arg = 8'h0A; zero_oob = 1; fetch_inact = 1;
    exec = ALL; row_en = 4'hF; bank_en = 4'hF; wave32 = 0;
    for (int l = 0; l < NL; l++) src[l*W +: W] = lane_val(16'h9001, l);
    @(negedge clk);
    chk_bit("R1 vld single pulse", vld, 1'b0);
    chk_lanes("R10 idle no change");
    repeat (3) @(negedge clk);
    chk_lanes("R10 idle long");
  endtask

  initial begin
    rst_n = 1'b0; issue = 0; op = 0; arg = 0; row_en = 4'hF; bank_en = 4'hF;
    zero_oob = 0; fetch_inact = 0; wave32 = 0; exec = '0; src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_quad();
    t_mirror();
    t_share_xor();
    t_shift();
    t_reserved();
    t_inactive();
    t_masks();
    t_wave32();
    t_idle();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule